// File: doc/BRIEF.md
# Indirect MAC Register Access Bridge

This block lets a host processor reach a wide internal MAC register file through a handful of byte-wide registers. The host loads a 16-bit target address into one of two address pairs: one pair serves writes, the other serves reads. For a write it also loads a 32-bit data word. It then writes the control register with a direction bit and a start bit. The start bit stays at 1 while the operation runs and doubles as the busy flag that the host polls.

On the MAC side the bridge issues a one-cycle request strobe together with address, direction and write data, then waits for a one-cycle done pulse. Read data is captured into a host-readable data register on the same clock edge that clears the busy flag, so the data is valid as soon as the host sees the flag at 0. If done never arrives, a timeout counter ends the operation and sets a sticky error flag. While an operation is in flight, all host writes are dropped. The MAC port has no back-pressure: the strobe is a one-shot request, the done pulse is the only acknowledgement, and only one request is ever outstanding. The host register port is a plain synchronous byte interface with a combinational read path.

Top module: `mac_reg_bridge`

## Requirements
- R1: After reset every host-readable offset reads 0x00 and `mac_req` is low.
- R2: Offsets 0x0 (bits 7..0) and 0x1 (bits 15..8) hold the write-target address, and offsets 0x4..0x7 hold the write data (offset 0x4 = bits 7..0). A write command drives these values on `mac_addr` and `mac_wdata` with `mac_we`=1.
- R3: Offsets 0x2 (bits 7..0) and 0x3 (bits 15..8) hold the read-target address. A read command drives it on `mac_addr` with `mac_we`=0, and never uses the write-address pair.
- R4: In the control register at offset 0xC, bit 1 is the direction (1 = read, 0 = write). A host write with bit 0 = 1 launches the command using the direction value carried in that same host write.
- R5: A launch raises `mac_req` for exactly one cycle, in the cycle that follows the launching host write edge.
- R6: Control bit 0 reads 1 from the launching edge until the edge on which `mac_done` is sampled high, and reads 0 from that edge on.
- R7: On completion of a read, `mac_rdata` is latched into offsets 0x8..0xB (offset 0x8 = bits 7..0) on the same edge that clears control bit 0.
- R8: While control bit 0 is 1, host writes to every offset are ignored, including the control register.
- R9: If `mac_done` has not arrived after TMO_CYC busy cycles, control bit 0 clears, control bit 2 (error) is set to 1, and the read-data register keeps its old value.
- R10: The error bit is sticky: a successful command leaves it at 1, and writing 1 to control bit 2 while idle clears it.
- R11: A control write with bit 0 = 0 stores the direction bit and launches nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host byte write enable |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational from host_addr) |
| mac_req | output | 1 | One-cycle request strobe to the MAC |
| mac_we | output | 1 | 1 = write, 0 = read |
| mac_addr | output | 16 | MAC register address |
| mac_wdata | output | 32 | MAC write data |
| mac_rdata | input | 32 | MAC read data, valid with mac_done |
| mac_done | input | 1 | One-cycle completion pulse from the MAC |

## Verification
The bench builds the bridge with TMO_CYC set to 16 instead of 256, so a command against a MAC model that never answers expires within a few dozen cycles. This makes the exact busy length on timeout, the sticky error and its clearing, and the unchanged read data all cheap to reach. The MAC model's response latency is set per vector, from one cycle up to long enough to drop host writes during a busy window.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  // host register offsets
  localparam logic [3:0] OFS_WA_LO = 4'h0;
  localparam logic [3:0] OFS_RA_LO = 4'h2;
  localparam logic [3:0] OFS_WD0   = 4'h4;
  localparam logic [3:0] OFS_RD0   = 4'h8;
  localparam logic [3:0] OFS_CTRL  = 4'hC;
  // control bit positions
  localparam int CTL_GO  = 0;
  localparam int CTL_DIR = 1;
  localparam int CTL_ERR = 2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_st_t;
endpackage

// File: rtl/mrb_host_regs.sv
module mrb_host_regs
  import mrb_pkg::*;
#(
  parameter int HAW = 4,
  parameter int AW  = 16,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic [HAW-1:0] host_addr,
  input  logic [7:0]     host_wdata,
  output logic [7:0]     host_rdata,
  input  logic           busy,
  input  logic           rd_capture,
  input  logic [DW-1:0]  rd_word,
  input  logic           tmo_hit,
  output logic [AW-1:0]  waddr,
  output logic [AW-1:0]  raddr,
  output logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rd_hold,
  output logic           dir,
  output logic           err,
  output logic           launch
);
  localparam int NAB = AW / 8;
  localparam int NDB = DW / 8;

  logic wr_ok, ctrl_wr;

  // writes are dropped while a command is in flight
  assign wr_ok   = host_we && !busy;
  assign ctrl_wr = wr_ok && (host_addr == HAW'(OFS_CTRL));
  assign launch  = ctrl_wr && host_wdata[CTL_GO];

  for (genvar i = 0; i < NAB; i++) begin : g_abyte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        waddr[8*i +: 8] <= '0;
        raddr[8*i +: 8] <= '0;
      end else if (wr_ok) begin
        if (host_addr == HAW'(OFS_WA_LO + i)) waddr[8*i +: 8] <= host_wdata;
        if (host_addr == HAW'(OFS_RA_LO + i)) raddr[8*i +: 8] <= host_wdata;
      end
    end
  end

  for (genvar i = 0; i < NDB; i++) begin : g_dbyte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wdata[8*i +: 8] <= '0;
      end else if (wr_ok && host_addr == HAW'(OFS_WD0 + i)) begin
        wdata[8*i +: 8] <= host_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_hold[8*i +: 8] <= '0;
      end else if (rd_capture) begin
        rd_hold[8*i +: 8] <= rd_word[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= 1'b0;
      err <= 1'b0;
    end else begin
      if (ctrl_wr) dir <= host_wdata[CTL_DIR];
      if (tmo_hit) err <= 1'b1;
      else if (ctrl_wr && host_wdata[CTL_ERR]) err <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    for (int i = 0; i < NAB; i++) begin
      if (host_addr == HAW'(OFS_WA_LO + i)) host_rdata = waddr[8*i +: 8];
      if (host_addr == HAW'(OFS_RA_LO + i)) host_rdata = raddr[8*i +: 8];
    end
    for (int i = 0; i < NDB; i++) begin
      if (host_addr == HAW'(OFS_WD0 + i)) host_rdata = wdata[8*i +: 8];
      if (host_addr == HAW'(OFS_RD0 + i)) host_rdata = rd_hold[8*i +: 8];
    end
    if (host_addr == HAW'(OFS_CTRL)) begin
      host_rdata[CTL_GO]  = busy;
      host_rdata[CTL_DIR] = dir;
      host_rdata[CTL_ERR] = err;
    end
  end
endmodule

// File: rtl/mrb_seq.sv
module mrb_seq
  import mrb_pkg::*;
#(
  parameter int TMO_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic dir,
  input  logic mac_done,
  output logic busy,
  output logic mac_req,
  output logic rd_capture,
  output logic tmo_hit
);
  localparam int CW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

  seq_st_t       st;
  logic [CW-1:0] cnt;
  logic          ending;

  assign busy       = (st != SQ_IDLE);
  assign mac_req    = (st == SQ_REQ);
  assign rd_capture = busy && mac_done && dir;
  assign tmo_hit    = busy && !mac_done && (cnt == CW'(TMO_CYC - 1));
  assign ending     = busy && (mac_done || tmo_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          cnt <= '0;
          if (launch) st <= SQ_REQ;
        end
        SQ_REQ, SQ_WAIT: begin
          if (ending) begin
            st  <= SQ_IDLE;
            cnt <= '0;
          end else begin
            st  <= SQ_WAIT;
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_reg_bridge.sv
module mac_reg_bridge #(
  parameter int HAW     = 4,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int TMO_CYC = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic [HAW-1:0] host_addr,
  input  logic [7:0]     host_wdata,
  output logic [7:0]     host_rdata,
  output logic           mac_req,
  output logic           mac_we,
  output logic [AW-1:0]  mac_addr,
  output logic [DW-1:0]  mac_wdata,
  input  logic [DW-1:0]  mac_rdata,
  input  logic           mac_done
);
  logic          busy, rd_capture, tmo_hit, dir, err, launch;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rd_hold;

  mrb_host_regs #(.HAW(HAW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy(busy), .rd_capture(rd_capture), .rd_word(mac_rdata), .tmo_hit(tmo_hit),
    .waddr(waddr), .raddr(raddr), .wdata(wdata), .rd_hold(rd_hold),
    .dir(dir), .err(err), .launch(launch)
  );

  mrb_seq #(.TMO_CYC(TMO_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .dir(dir), .mac_done(mac_done),
    .busy(busy), .mac_req(mac_req), .rd_capture(rd_capture), .tmo_hit(tmo_hit)
  );

  // each direction takes its address from its own pair
  assign mac_addr  = dir ? raddr : waddr;
  assign mac_we    = !dir;
  assign mac_wdata = wdata;
endmodule

// File: rtl/mrb_bridge_chk.sv
module mrb_bridge_chk #(
  parameter int HAW     = 4,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int TMO_CYC = 256
) (
  input logic           clk,
  input logic           rst_n,
  input logic           host_we,
  input logic [HAW-1:0] host_addr,
  input logic [7:0]     host_wdata,
  input logic           mac_req,
  input logic           mac_we,
  input logic [AW-1:0]  mac_addr,
  input logic [DW-1:0]  mac_wdata,
  input logic [DW-1:0]  mac_rdata,
  input logic           mac_done,
  input logic           busy,
  input logic [DW-1:0]  rd_hold
);
  localparam int BW = $clog2(TMO_CYC + 1) + 1;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else bcnt <= '0;
  end

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mac_req |=> !mac_req);
  p_launch_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == HAW'(mrb_pkg::OFS_CTRL) && host_wdata[0] && !busy) |=> mac_req);
  p_req_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mac_req |-> busy);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mac_addr) && $stable(mac_we) && $stable(mac_wdata)));
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mac_done && !mac_we) |=> (rd_hold == $past(mac_rdata) && !busy));
  p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BW'(TMO_CYC));
  p_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(mac_done) || bcnt == BW'(TMO_CYC)));
endmodule

bind mac_reg_bridge mrb_bridge_chk #(.HAW(HAW), .AW(AW), .DW(DW), .TMO_CYC(TMO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
  .mac_req(mac_req), .mac_we(mac_we), .mac_addr(mac_addr), .mac_wdata(mac_wdata),
  .mac_rdata(mac_rdata), .mac_done(mac_done),
  .busy(busy), .rd_hold(rd_hold)
);

// File: tb/test_mac_reg_bridge.sv
module test_mac_reg_bridge;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = 4'h0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        mac_req, mac_we, mac_done;
  logic [15:0] mac_addr;
  logic [31:0] mac_wdata, mac_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mac_reg_bridge #(.TMO_CYC(TMO)) i_mac_reg_bridge (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .mac_req(mac_req), .mac_we(mac_we), .mac_addr(mac_addr), .mac_wdata(mac_wdata),
    .mac_rdata(mac_rdata), .mac_done(mac_done)
  );

  // ---------------- MAC model ----------------
  int          lat_cfg = 1;
  bit          mute = 1'b0;
  int          req_cnt = 0;
  logic [15:0] cap_addr = '0;
  logic        cap_we = 1'b0;
  logic [31:0] cap_wdata = '0;
  int          cd = 0;

  function automatic logic [31:0] mac_val(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  always @(posedge clk) begin
    if (mac_req) begin
      req_cnt   <= req_cnt + 1;
      cap_addr  <= mac_addr;
      cap_we    <= mac_we;
      cap_wdata <= mac_wdata;
      cd        <= mute ? 0 : lat_cfg;
    end else if (cd != 0) begin
      cd <= cd - 1;
    end
  end
  assign mac_done  = (cd == 1);
  assign mac_rdata = mac_val(cap_addr);

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [3:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic poll(output int n);
    logic [7:0] c;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      hr(4'hC, c);
      if (!c[0]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd32(input logic [3:0] base, output logic [31:0] w);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      hr(base + 4'(i), b);
      w[8*i +: 8] = b;
    end
  endtask

  // vector: {dir, lat[3:0], addr[15:0], data[31:0]}
  localparam logic [52:0] VEC [6] = '{
    {1'b0, 4'd1, 16'h0123, 32'hDEADBEEF},
    {1'b1, 4'd1, 16'hA5F0, 32'h00000000},
    {1'b0, 4'd3, 16'hFFFF, 32'h12345678},
    {1'b1, 4'd5, 16'h0000, 32'h0},
    {1'b1, 4'd2, 16'h8001, 32'h0},
    {1'b0, 4'd7, 16'h7E00, 32'hFFFFFFFF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] w, keep;
    int n, r0;

    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      hr(4'(a), b);
      chk("R1 reset read", {24'h0, b}, 32'h0);
    end
    chk("R1 req low in reset", {31'h0, mac_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    hr(4'hC, b);
    chk("R1 ctrl after reset", {24'h0, b}, 32'h0);

    // vector table: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      logic        dv;
      logic [15:0] av, other;
      logic [31:0] dd;
      dv = VEC[v][52]; lat_cfg = int'(VEC[v][51:48]);
      av = VEC[v][47:32]; dd = VEC[v][31:0];
      other = ~av;
      hw(4'h0, dv ? other[7:0]  : av[7:0]);
      hw(4'h1, dv ? other[15:8] : av[15:8]);
      hw(4'h2, dv ? av[7:0]  : other[7:0]);
      hw(4'h3, dv ? av[15:8] : other[15:8]);
      for (int i = 0; i < 4; i++) hw(4'h4 + 4'(i), dd[8*i +: 8]);
      r0 = req_cnt;
      hw(4'hC, {6'h0, dv, 1'b1});
      poll(n);
      chk("R6 busy length", n, lat_cfg + 1);
      chk("R5 one strobe", req_cnt - r0, 1);
      chk(dv ? "R3 read address" : "R2 write address", {16'h0, cap_addr}, {16'h0, av});
      chk("R4 direction", {31'h0, cap_we}, {31'h0, !dv});
      if (!dv) chk("R2 write data", cap_wdata, dd);
      else begin
        rd32(4'h8, w);
        chk("R7 read data", w, mac_val(av));
      end
      hr(4'hC, b);
      chk("R6 ctrl idle", {24'h0, b}, {30'h0, dv, 1'b0});
    end

    // R11: control write without start stores direction only
    lat_cfg = 1;
    r0 = req_cnt;
    hw(4'hC, 8'h02);
    repeat (3) @(negedge clk);
    chk("R11 no launch", req_cnt - r0, 0);
    hr(4'hC, b);
    chk("R11 dir stored", {24'h0, b}, 32'h2);
    // R4: same-write direction wins over stored one
    hw(4'h0, 8'h34); hw(4'h1, 8'h12);
    hw(4'hC, 8'h01);
    poll(n);
    chk("R4 same-write dir", {31'h0, cap_we}, 32'h1);
    chk("R4 write addr", {16'h0, cap_addr}, 32'h1234);

    // R8: writes during busy are ignored
    lat_cfg = 10;
    r0 = req_cnt;
    hw(4'hC, 8'h01);
    hw(4'h0, 8'hEE);
    hw(4'hC, 8'h03);
    poll(n);
    chk("R8 single strobe", req_cnt - r0, 1);
    hr(4'h0, b);
    chk("R8 addr unchanged", {24'h0, b}, 32'h34);
    hr(4'hC, b);
    chk("R8 ctrl unchanged", {24'h0, b}, 32'h0);

    // R9: timeout
    rd32(4'h8, keep);
    mute = 1'b1;
    hw(4'h2, 8'h99);
    hw(4'hC, 8'h03);
    poll(n);
    chk("R9 timeout length", n, TMO);
    hr(4'hC, b);
    chk("R9 error set", {24'h0, b}, 32'h6);
    rd32(4'h8, w);
    chk("R9 rdata kept", w, keep);
    mute = 1'b0;

    // R10: sticky error, cleared by write-1
    lat_cfg = 2;
    hw(4'hC, 8'h01);
    poll(n);
    hr(4'hC, b);
    chk("R10 error sticky", {24'h0, b}, 32'h4);
    hw(4'hC, 8'h04);
    hr(4'hC, b);
    chk("R10 error cleared", {24'h0, b}, 32'h0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule